// File: doc/BRIEF.md
# Multi-Source Standby Wakeup Controller

This block holds the wakeup-flag logic for a low-power standby state. A parameterised number of wakeup lines come in, and each line has its own enable bit. Every line passes through its own synchronizer and then its own rising-edge detector, and the detector only acts while that line is enabled. The combining happens after edge detection, in a per-line pending register. A line that stays high therefore cannot hide a later rising edge on any other line. The sticky wakeup flag is the OR of the pending bits. Software can read the pending bits to see which line caused a wake.

Software clears every pending bit with a one-cycle clear strobe. It asks for standby with a one-cycle request. A request made while the flag is set, or while an enabled line is high, is refused: the block gives an immediate one-cycle wake pulse instead. In the second case the pulse also carries a marker telling the reset generator to treat the wake as a power reset. While in standby, a rising edge on any enabled line produces the wake pulse and returns the block to the run state.

Top module: `standby_wake_ctrl`

## Requirements
- R1: After reset, `pending`, `flag`, `wake_req`, `wake_por` and `in_standby` are all 0.
- R2: Each line is synchronized by two flops. A line that rises just before clock edge n sets its pending bit, and that bit is visible after edge n+2 but not after edge n+1.
- R3: Only a low-to-high transition of an enabled line sets its pending bit. A line that stays high sets nothing more after a clear.
- R4: A line whose enable bit is 0 never sets its pending bit, whatever it does.
- R5: When the enable bit of a line goes from 0 to 1 while that line is already high, the pending bit is not set.
- R6: Pending bits are sticky until cleared. `flag` is 1 exactly when any pending bit is 1.
- R7: A clear strobe zeroes every pending bit one cycle later. The exception is a bit whose line shows a new enabled edge in the same cycle as the strobe: that bit stays set, and so does `flag`.
- R8: A standby request made while `flag` is set gives a one-cycle `wake_req` with `wake_por` 0, and standby is not entered.
- R9: A standby request made while `flag` is clear but an enabled line is high gives a one-cycle `wake_req` with `wake_por` 1, and standby is not entered.
- R10: Otherwise a standby request sets `in_standby`. While in standby, a rising edge on an enabled line gives a one-cycle `wake_req` (with `wake_por` 0), clears `in_standby`, and sets that line's pending bit.
- R11: One line held high does not stop a rising edge on another enabled line from setting that line's bit. After all enables are dropped, a clear is given and the enables are restored, a later edge still wakes the block from standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | N_SRC | Asynchronous wakeup lines |
| src_en | input | N_SRC | Per-line enable bits |
| flag_clr | input | 1 | Write-one clear strobe for all pending bits |
| standby_req | input | 1 | One-cycle request to enter standby |
| pending | output | N_SRC | Per-line sticky pending bits |
| flag | output | 1 | Sticky wakeup flag (OR of pending bits) |
| wake_req | output | 1 | One-cycle wake pulse to the power controller |
| wake_por | output | 1 | Qualifies `wake_req` as a power-reset wake |
| in_standby | output | 1 | Block is in the standby state |

## Verification
The assertions check on every cycle that:
- a pending bit holds until a clear;
- an edge beats a simultaneous clear;
- a pending bit only rises on an enabled line;
- the power-reset marker never appears without a wake pulse;
- standby is never entered while the flag is set;
- an edge seen in standby always produces a wake.

Other behaviour needs the bench's scenarios, because it depends on how the lines and enables move over many cycles. This covers the two-flop latency, blindness to a line that stays high, ignoring a line re-enabled while high, and the full disable-clear-re-enable sequence before standby. Random line patterns check the pending bits against an independent model.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
    // Power-mode state of the controller
    typedef enum logic [0:0] {
        PM_RUN     = 1'b0,
        PM_STANDBY = 1'b1
    } pm_state_e;

    // Registered wake output pair
    typedef struct packed {
        logic req;
        logic por;
    } wake_evt_t;

    localparam int unsigned SYNC_MIN = 2;

    function automatic wake_evt_t wake_none();
        wake_evt_t w;
        w.req = 1'b0;
        w.por = 1'b0;
        return w;
    endfunction

    function automatic wake_evt_t wake_make(input logic por);
        wake_evt_t w;
        w.req = 1'b1;
        w.por = por;
        return w;
    endfunction
endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int unsigned NS = (STAGES < wkup_pkg::SYNC_MIN) ? wkup_pkg::SYNC_MIN : STAGES;

    logic [NS-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[NS-2:0], d};
    end

    assign q = sh[NS-1];
endmodule

// File: rtl/wk_edge.sv
module wk_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic en,
    input  logic clr,
    output logic edge_o,
    output logic pend_o
);
    logic prev_q;
    logic en_q;
    logic pend_q;

    // An edge needs the enable high now and in the previous cycle, so a
    // line already high at re-enable is treated as a level, not an edge.
    assign edge_o = en & en_q & lvl & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            en_q   <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= lvl;
            en_q   <= en;
            if (edge_o)   pend_q <= 1'b1;
            else if (clr) pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;

    // R6: a pending bit holds until a clear
    a_r6_pend_sticky: assert property (@(posedge clk) disable iff (rst)
        (pend_o && !clr) |=> pend_o);
    // R7: an edge wins over a clear in the same cycle
    a_r7_edge_wins: assert property (@(posedge clk) disable iff (rst)
        edge_o |=> pend_o);
    // R7: a clear without an edge empties the bit
    a_r7_clear_empties: assert property (@(posedge clk) disable iff (rst)
        (clr && !edge_o) |=> !pend_o);
    // R4: a bit can only rise on an enabled line
    a_r4_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_o) |-> $past(en));
endmodule

// File: rtl/wk_fsm.sv
module wk_fsm (
    input  logic clk,
    input  logic rst,
    input  logic standby_req,
    input  logic pend_any,
    input  logic edge_any,
    input  logic lvl_any,
    output logic wake_req,
    output logic wake_por,
    output logic in_standby
);
    import wkup_pkg::*;

    pm_state_e state_q, state_d;
    wake_evt_t wake_q, wake_d;

    always_comb begin
        state_d = state_q;
        wake_d  = wake_none();
        unique case (state_q)
            PM_RUN: begin
                if (standby_req) begin
                    if (pend_any || edge_any) wake_d  = wake_make(1'b0);
                    else if (lvl_any)         wake_d  = wake_make(1'b1);
                    else                      state_d = PM_STANDBY;
                end
            end
            PM_STANDBY: begin
                if (edge_any) begin
                    wake_d  = wake_make(1'b0);
                    state_d = PM_RUN;
                end
            end
            default: state_d = PM_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PM_RUN;
            wake_q  <= wake_none();
        end else begin
            state_q <= state_d;
            wake_q  <= wake_d;
        end
    end

    assign wake_req   = wake_q.req;
    assign wake_por   = wake_q.por;
    assign in_standby = (state_q == PM_STANDBY);

    // R9: the power-reset marker is only a qualifier of a wake pulse
    a_r9_por_with_wake: assert property (@(posedge clk) disable iff (rst)
        wake_por |-> wake_req);
    // R8: standby never entered while the flag is set
    a_r8_no_entry_flagged: assert property (@(posedge clk) disable iff (rst)
        $rose(in_standby) |-> !$past(pend_any));
    // R10: an edge seen in standby always wakes
    a_r10_edge_wakes: assert property (@(posedge clk) disable iff (rst)
        (in_standby && edge_any) |=> (wake_req && !in_standby));
    // R8: a flagged request gives a wake without standby
    a_r8_flag_wake: assert property (@(posedge clk) disable iff (rst)
        (!in_standby && standby_req && pend_any) |=> (wake_req && !wake_por && !in_standby));
endmodule

// File: rtl/standby_wake_ctrl.sv
module standby_wake_ctrl #(
    parameter int unsigned N_SRC       = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src_in,
    input  logic [N_SRC-1:0] src_en,
    input  logic             flag_clr,
    input  logic             standby_req,
    output logic [N_SRC-1:0] pending,
    output logic             flag,
    output logic             wake_req,
    output logic             wake_por,
    output logic             in_standby
);
    logic [N_SRC-1:0] lvl_s;
    logic [N_SRC-1:0] edge_v;
    logic [N_SRC-1:0] pend_v;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        wk_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (src_in[i]),
            .q   (lvl_s[i])
        );
        wk_edge u_edge (
            .clk    (clk),
            .rst    (rst),
            .lvl    (lvl_s[i]),
            .en     (src_en[i]),
            .clr    (flag_clr),
            .edge_o (edge_v[i]),
            .pend_o (pend_v[i])
        );
    end

    wk_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .standby_req (standby_req),
        .pend_any    (|pend_v),
        .edge_any    (|edge_v),
        .lvl_any     (|(lvl_s & src_en)),
        .wake_req    (wake_req),
        .wake_por    (wake_por),
        .in_standby  (in_standby)
    );

    assign pending = pend_v;
    assign flag    = |pend_v;

    // R6: flag tracks the pending bits
    a_r6_flag_matches: assert property (@(posedge clk) disable iff (rst)
        flag == (pending != '0));
endmodule

// File: tb/sim_standby_wake_ctrl.sv
module sim_standby_wake_ctrl;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] src_in, src_en;
    logic         flag_clr, standby_req;
    logic [N-1:0] pending;
    logic         flag, wake_req, wake_por, in_standby;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    standby_wake_ctrl #(.N_SRC(N), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .src_in(src_in), .src_en(src_en),
        .flag_clr(flag_clr), .standby_req(standby_req),
        .pending(pending), .flag(flag), .wake_req(wake_req),
        .wake_por(wake_por), .in_standby(in_standby)
    );

    // Expected pending after a settled line change with enables held (R3, R4, R6)
    function automatic logic [N-1:0] exp_pend(input logic [N-1:0] old_l,
            input logic [N-1:0] new_l, input logic [N-1:0] en, input logic [N-1:0] p);
        return p | (new_l & ~old_l & en);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
    endtask

    task automatic pulse_sby();
        standby_req = 1'b1; tick(1); standby_req = 1'b0;
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] lv, ex, nl;
        int unsigned seed;
        rst = 1'b1; src_in = '0; src_en = '0; flag_clr = 1'b0; standby_req = 1'b0;
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        chk("R1 pending", pending, 0);
        chk("R1 flag/wake/por/sby", {flag, wake_req, wake_por, in_standby}, 0);

        // R2 latency
        src_en = 4'hF; tick(2);
        src_in = 4'b0001;
        tick(2); chk("R2 not yet", pending, 4'b0000);
        tick(1); chk("R2 set", pending, 4'b0001);
        chk("R6 flag", flag, 1);

        // R3 held level does not retrigger; R7 clear
        pulse_clr(); chk("R7 cleared", pending, 0);
        tick(4); chk("R3 held no retrigger", pending, 0);

        // R11 held line does not blind another
        src_in = 4'b0101; tick(4);
        chk("R11 other line seen", pending, 4'b0100);

        // R7 edge wins over same-cycle clear
        src_in = 4'b0111; tick(2);
        pulse_clr();
        chk("R7 edge wins", pending, 4'b0010);
        chk("R7 flag kept", flag, 1);
        pulse_clr();

        // R4 disabled line ignored
        src_en = 4'b0111; tick(2);
        src_in = 4'b1111; tick(4);
        chk("R4 disabled ignored", pending, 0);

        // R5 re-enable while high
        src_en = 4'hF; tick(4);
        chk("R5 no edge at re-enable", pending, 0);

        // R8 flagged request
        src_in = 4'b0000; tick(4);
        src_in = 4'b1000; tick(4);
        pulse_sby();
        chk("R8 wake no por", {wake_req, wake_por, in_standby}, 3'b100);
        tick(1); chk("R8 pulse one cycle", wake_req, 0);

        // R11 disable/clear/re-enable with a line high, then R9
        src_in = 4'b0001; tick(4);
        src_en = '0; tick(1);
        pulse_clr();
        src_en = 4'hF; tick(2);
        chk("R11 armed clean", pending, 0);
        pulse_sby();
        chk("R9 por wake", {wake_req, wake_por, in_standby}, 3'b110);
        tick(1); chk("R9 pulse one cycle", {wake_req, wake_por}, 0);

        // R10 standby and wake
        src_in = 4'b0000; tick(4);
        pulse_sby();
        chk("R10 in standby", {wake_req, in_standby}, 2'b01);
        tick(5); chk("R10 stays", in_standby, 1);
        src_in = 4'b0010;
        tick(2); chk("R10 no wake yet", wake_req, 0);
        tick(1);
        chk("R10 wake", {wake_req, wake_por, in_standby}, 3'b100);
        chk("R10 cause", pending, 4'b0010);
        tick(1); chk("R10 pulse one cycle", wake_req, 0);
        pulse_clr();

        // Random phase (R3, R4, R6)
        seed = 32'd1234;
        void'($urandom(seed));
        lv = src_in;
        ex = pending;
        for (int k = 0; k < 60; k++) begin
            if (k % 10 == 0) begin
                src_en = 4'($urandom()); tick(4);
                chk("R5 enable change", pending, ex);
            end
            if (k % 7 == 3) begin
                pulse_clr(); tick(3); ex = '0;
            end
            nl = 4'($urandom());
            src_in = nl; tick(4);
            ex = exp_pend(lv, nl, src_en, ex);
            lv = nl;
            chk("R3 random", pending, ex);
            chk("R6 random flag", flag, (ex != 0));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule